// File: doc/BRIEF.md
# Flash Bulk Erase-Verify Sequencer

This block erases a command-driven byte-wide parallel flash across an address window and confirms that every byte in that window reads back as erased. Erasing is a device-wide operation, so the sequencer first brings every byte of the window to 0x00 with a program-then-verify step that retries a bounded number of times. Only then does it start erasing. Each erase cycle is a doubled erase command followed by a long settling wait.

After an erase the sequencer walks the window with erase-verify reads. A passing byte advances the pointer with no new erase. A failing byte triggers another erase at that same address, and the walk continues from there. One erase-cycle counter, shared by the whole operation, limits the total effort. Whether the operation passes or fails, it finishes by writing the read-mode command, then reports done and the result.

The host pulses `start_i` with a base address and an exclusive end address. It then waits for `done_o` and reads `pass_o`. Both wait lengths are parameters counted in clock cycles. The default erase wait is sized for about 12 ms at 125 MHz.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `pass_o` are low and neither `fl_we_o` nor `fl_re_o` is asserted.
- R2: A `start_i` pulse while idle captures the window and raises `busy_o` on the next cycle. `busy_o` stays high until completion. A `start_i` while busy has no effect on the running sequence.
- R3: Before any erase, each address from base up to end-1 is visited in ascending order. At each address the block writes the program command 0x40 followed by the data byte 0x00.
- R4: After the data write, at least PROG_WAIT idle bus cycles pass. The block then writes 0xC0 and reads the byte, with read data valid the cycle after `fl_re_o`, and expects 0x00. A mismatch retries the address, up to PROG_TRIES attempts in total. If every attempt fails, the block ends with failure and issues no erase.
- R5: An erase cycle is two consecutive-cycle writes of 0x20 to the current address, followed by at least ERASE_WAIT idle bus cycles.
- R6: Erase verify writes 0xA0 to an address, reads it back and expects 0xFF. On a match it moves to the next address with no new erase cycle. A match at end-1 ends with pass.
- R7: On an erase-verify mismatch, a new erase cycle starts at the current address. The verify pointer never moves back.
- R8: At most ERASE_MAX erase cycles are issued per operation. A mismatch after the last allowed cycle ends with failure.
- R9: Every ending writes 0x00 (read mode) as the final bus access. It then pulses `done_o` for one cycle with `busy_o` low. `pass_o` holds the result until the next start.
- R10: The erase-cycle count is cleared by each new start, so a previous run's count does not carry over.
- R11: A window with end <= base performs no program or erase. It only writes read mode and ends with pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| base_addr_i | input | AW | First address of the window |
| end_addr_i | input | AW | Exclusive end address of the window |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last completed sequence |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | 8 | Flash write data / command byte |
| fl_we_o | output | 1 | Flash write strobe, one byte per cycle |
| fl_re_o | output | 1 | Flash read strobe |
| fl_rdata_i | input | 8 | Flash read data, valid the cycle after `fl_re_o` |

## Verification
The bench sets up a small window against a behavioural flash model. In that model, each byte needs a chosen number of program attempts and a chosen number of erases before it reads as programmed or erased.

The bench drives the following corners:
- A byte that needs several erases. A design that rewinds the verify pointer would be caught by the monotonic-address check. A design that counts erases wrongly would report the wrong total.
- Exhausting the erase cap, followed by a fresh run that needs two erases. A counter that is not cleared on start would fail that second run at once.
- A program step that runs out of retries. A design that erases anyway, or miscounts attempts, shows a wrong program-command total or an erase.
- An empty window, and a start issued mid-run. A design that does not ignore the stray start restarts, and the extra program commands reveal it.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_P_CMD, S_P_DATA, S_P_WAIT, S_P_VCMD, S_P_READ, S_P_CHK,
    S_E_CMD1, S_E_CMD2, S_E_WAIT, S_V_CMD, S_V_READ, S_V_CHK, S_RESTORE
  } state_e;

  localparam logic [7:0] CMD_PROG   = 8'h40;
  localparam logic [7:0] CMD_PVFY   = 8'hC0;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_EVFY   = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] PAT_ZERO   = 8'h00;
  localparam logic [7:0] PAT_ERASED = 8'hFF;
endpackage

// File: rtl/fes_wait.sv
module fes_wait #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (!hit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && (cnt_q == limit_i - 1'b1);

  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q < limit_i); // R5
endmodule

// File: rtl/fes_counter.sv
module fes_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (inc_i)  q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PROG_WAIT  = 1250,
  parameter int ERASE_WAIT = 1500000,
  parameter int PROG_TRIES = 25,
  parameter int ERASE_MAX  = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [AW-1:0] end_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  output logic          fl_we_o,
  output logic          fl_re_o,
  input  logic [7:0]    fl_rdata_i
);
  localparam int WMAX = (PROG_WAIT > ERASE_WAIT) ? PROG_WAIT : ERASE_WAIT;
  localparam int WW   = $clog2(WMAX + 1);
  localparam int TW   = $clog2(PROG_TRIES + 1);
  localparam int EW   = $clog2(ERASE_MAX + 1);
  localparam logic [WW-1:0] P_LIM = WW'(PROG_WAIT);
  localparam logic [WW-1:0] E_LIM = WW'(ERASE_WAIT);
  localparam logic [TW-1:0] T_LAST = TW'(PROG_TRIES - 1);
  localparam logic [EW-1:0] E_LAST = EW'(ERASE_MAX);

  state_e        state_q;
  logic [AW-1:0] addr_q, base_q, end_q;
  logic          ok_q, pass_q, done_q;
  logic          accept, last, wait_en, wait_hit, rd_zero, rd_erased;
  logic [TW-1:0] tries;
  logic [EW-1:0] erase_cnt;

  assign accept    = (state_q == S_IDLE) && start_i;
  assign last      = (addr_q == end_q - 1'b1);
  assign rd_zero   = (fl_rdata_i == PAT_ZERO);
  assign rd_erased = (fl_rdata_i == PAT_ERASED);
  assign wait_en   = (state_q == S_P_WAIT) || (state_q == S_E_WAIT);

  fes_wait #(.W(WW)) u_wait (
    .clk_i, .rst_ni, .en_i(wait_en),
    .limit_i((state_q == S_E_WAIT) ? E_LIM : P_LIM),
    .hit_o(wait_hit)
  );

  // failed program attempts at the current address
  fes_counter #(.W(TW)) u_tries (
    .clk_i, .rst_ni,
    .clr_i(accept || (state_q == S_P_CHK && rd_zero)),
    .inc_i(state_q == S_P_CHK && !rd_zero),
    .q_o(tries)
  );

  // erase cycles issued in this operation
  fes_counter #(.W(EW)) u_erases (
    .clk_i, .rst_ni,
    .clr_i(accept),
    .inc_i(state_q == S_E_CMD2),
    .q_o(erase_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      base_q  <= '0;
      end_q   <= '0;
      ok_q    <= 1'b0;
      pass_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          base_q <= base_addr_i;
          end_q  <= end_addr_i;
          addr_q <= base_addr_i;
          pass_q <= 1'b0;
          if (end_addr_i > base_addr_i) state_q <= S_P_CMD;
          else begin
            ok_q    <= 1'b1;
            state_q <= S_RESTORE;
          end
        end
        S_P_CMD:  state_q <= S_P_DATA;
        S_P_DATA: state_q <= S_P_WAIT;
        S_P_WAIT: if (wait_hit) state_q <= S_P_VCMD;
        S_P_VCMD: state_q <= S_P_READ;
        S_P_READ: state_q <= S_P_CHK;
        S_P_CHK: begin
          if (rd_zero) begin
            if (last) begin
              addr_q  <= base_q;
              state_q <= S_E_CMD1;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= S_P_CMD;
            end
          end else if (tries == T_LAST) begin
            ok_q    <= 1'b0;
            state_q <= S_RESTORE;
          end else state_q <= S_P_CMD;
        end
        S_E_CMD1: state_q <= S_E_CMD2;
        S_E_CMD2: state_q <= S_E_WAIT;
        S_E_WAIT: if (wait_hit) state_q <= S_V_CMD;
        S_V_CMD:  state_q <= S_V_READ;
        S_V_READ: state_q <= S_V_CHK;
        S_V_CHK: begin
          if (rd_erased) begin
            if (last) begin
              ok_q    <= 1'b1;
              state_q <= S_RESTORE;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= S_V_CMD;
            end
          end else if (erase_cnt == E_LAST) begin
            ok_q    <= 1'b0;
            state_q <= S_RESTORE;
          end else state_q <= S_E_CMD1; // retry from here, pointer kept
        end
        S_RESTORE: begin
          pass_q  <= ok_q;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_we_o    = 1'b0;
    fl_re_o    = 1'b0;
    fl_wdata_o = CMD_READ;
    unique case (state_q)
      S_P_CMD:             begin fl_we_o = 1'b1; fl_wdata_o = CMD_PROG;  end
      S_P_DATA:            begin fl_we_o = 1'b1; fl_wdata_o = PAT_ZERO;  end
      S_P_VCMD:            begin fl_we_o = 1'b1; fl_wdata_o = CMD_PVFY;  end
      S_E_CMD1, S_E_CMD2:  begin fl_we_o = 1'b1; fl_wdata_o = CMD_ERASE; end
      S_V_CMD:             begin fl_we_o = 1'b1; fl_wdata_o = CMD_EVFY;  end
      S_RESTORE:           begin fl_we_o = 1'b1; fl_wdata_o = CMD_READ;  end
      S_P_READ, S_V_READ:  fl_re_o = 1'b1;
      default: ;
    endcase
  end

  assign fl_addr_o = addr_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign pass_o    = pass_q;

  AST_BUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o)); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fl_we_o) |=> busy_o); // R2
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(fl_we_o) && $past(fl_wdata_o) == CMD_READ)); // R9
  AST_ERASE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_E_CMD1) |=> (fl_we_o && fl_wdata_o == CMD_ERASE && $stable(fl_addr_o))); // R5
  AST_ERASE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_cnt <= E_LAST); // R8
  AST_VFY_NO_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_V_CHK && !rd_erased) |=> $stable(fl_addr_o)); // R7
  AST_ADDR_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != S_RESTORE) |-> (addr_q >= base_q && addr_q < end_q)); // R3
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int AW = 16;
  localparam int PW = 5;
  localparam int EWT = 20;
  localparam int PT = 4;
  localparam int EM = 4;
  localparam int N = 16;
  localparam logic [AW-1:0] BASE = 16'h6000;

  logic clk = 0, rst_ni = 0, start = 0;
  logic [AW-1:0] base_a = BASE, end_a = BASE + N;
  logic busy, done, pass, we, re;
  logic [AW-1:0] faddr;
  logic [7:0] wdata, rdata = 8'h00;

  always #4 clk = ~clk;

  flash_erase_seq #(.AW(AW), .PROG_WAIT(PW), .ERASE_WAIT(EWT),
                    .PROG_TRIES(PT), .ERASE_MAX(EM)) u_dut (
    .clk_i(clk), .rst_ni, .start_i(start), .base_addr_i(base_a),
    .end_addr_i(end_a), .busy_o(busy), .done_o(done), .pass_o(pass),
    .fl_addr_o(faddr), .fl_wdata_o(wdata), .fl_we_o(we), .fl_re_o(re),
    .fl_rdata_i(rdata));

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] mem [N];
  int p_need [N], p_att [N], e_need [N], e_seen [N];
  int mode = 0, n_pcmd, n_erase, n_pok, prev_p, prev_v, t_pdata, t_erase;
  int bad_order, bad_pdata, bad_early, bad_pwait, bad_ewait, bad_pair, bad_rewind, bad_range;
  logic [7:0] last_w;
  logic pend_pair, pend_ewait;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural flash model and bus monitor
  always @(posedge clk) begin
    int idx;
    cyc++;
    idx = int'(faddr) - int'(BASE);
    if (we || re) begin
      if (idx < 0 || idx >= N) begin bad_range++; idx = 0; end
      if (pend_ewait) begin
        if (cyc - t_erase - 1 < EWT) bad_ewait++;
        pend_ewait <= 0;
      end
    end
    if (pend_pair && !(we && wdata == 8'h20)) bad_pair++;
    pend_pair <= 0;
    if (re) rdata <= mem[idx];
    if (we) begin
      last_w <= wdata;
      if (mode == 1) begin
        if (wdata != 8'h00) bad_pdata++;
        p_att[idx]++;
        if (p_att[idx] >= p_need[idx]) begin mem[idx] = mem[idx] & wdata; n_pok++; end
        t_pdata = cyc;
        mode = 0;
      end else if (mode == 3) begin
        if (wdata == 8'h20) begin
          n_erase++;
          if (n_pok < N) bad_early++;
          for (int a = 0; a < N; a++) begin
            e_seen[a]++;
            if (e_seen[a] >= e_need[a]) mem[a] = 8'hFF;
          end
          t_erase = cyc;
          pend_ewait <= 1;
        end
        mode = 0;
      end else begin
        case (wdata)
          8'h40: begin
            n_pcmd++;
            if (prev_p >= 0 && idx != prev_p && idx != prev_p + 1) bad_order++;
            prev_p = idx;
            mode = 1;
          end
          8'hC0: begin if (cyc - t_pdata - 1 < PW) bad_pwait++; mode = 2; end
          8'h20: begin mode = 3; pend_pair <= 1; end
          8'hA0: begin if (idx < prev_v) bad_rewind++; prev_v = idx; mode = 4; end
          default: mode = 0;
        endcase
      end
    end
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic prep(input int pn, input int en);
    for (int a = 0; a < N; a++) begin
      mem[a] = 8'h5A; p_need[a] = pn; p_att[a] = 0; e_need[a] = en; e_seen[a] = 0;
    end
    n_pcmd = 0; n_erase = 0; n_pok = 0; prev_p = -1; prev_v = -1; mode = 0;
    bad_order = 0; bad_pdata = 0; bad_early = 0; bad_pwait = 0; bad_ewait = 0;
    bad_pair = 0; bad_rewind = 0; bad_range = 0; pend_pair = 0; pend_ewait = 0;
  endtask

  task automatic run(input int mid_start, output bit got_done, output bit b_after);
    int n = 0;
    got_done = 0; b_after = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    b_after = busy;
    while (!done && n < 8000) begin
      n++;
      if (n == mid_start) begin
        base_a = BASE + 3; start = 1;
        @(negedge clk); start = 0; base_a = BASE;
      end else @(negedge clk);
    end
    got_done = done;
    chk(!busy, "R9 busy low with done", busy, 0);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
  endtask

  task automatic common(input string tag);
    chk(bad_order == 0, {tag, " R3 ascending program order"}, bad_order, 0);
    chk(bad_pdata == 0, {tag, " R3 program data 0x00"}, bad_pdata, 0);
    chk(bad_early == 0, {tag, " R3 erase before full program"}, bad_early, 0);
    chk(bad_pwait == 0, {tag, " R4 program wait"}, bad_pwait, 0);
    chk(bad_pair == 0 && bad_ewait == 0, {tag, " R5 erase pair/wait"}, bad_pair + bad_ewait, 0);
    chk(bad_rewind == 0, {tag, " R7 verify pointer monotonic"}, bad_rewind, 0);
    chk(bad_range == 0, {tag, " R3 address in window"}, bad_range, 0);
    chk(last_w == 8'h00, {tag, " R9 final read-mode write"}, last_w, 0);
  endtask

  initial begin
    bit d, b;
    prep(1, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !pass, "R1 status idle", {busy, done, pass}, 0);
    chk(!we && !re, "R1 bus quiet", {we, re}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R3 R6: clean run, one erase
    prep(1, 1); run(0, d, b);
    chk(b, "R2 busy after start", b, 1);
    chk(d && pass, "R6 clean pass", pass, 1);
    chk(n_pcmd == N, "R3 program commands", n_pcmd, N);
    chk(n_erase == 1, "R6 single erase", n_erase, 1);
    common("clean");

    // R7: byte 5 needs 3 erases
    prep(1, 1); e_need[5] = 3; run(0, d, b);
    chk(d && pass, "R7 stubborn pass", pass, 1);
    chk(n_erase == 3, "R7 erase count", n_erase, 3);
    common("stubborn");

    // R8: cap exceeded
    prep(1, 1); e_need[3] = EM + 2; run(0, d, b);
    chk(d && !pass, "R8 cap fail", pass, 0);
    chk(n_erase == EM, "R8 erases at cap", n_erase, EM);
    common("cap");

    // R10: counter cleared, run needing 2 erases everywhere
    prep(1, 2); run(0, d, b);
    chk(d && pass, "R10 fresh count pass", pass, 1);
    chk(n_erase == 2, "R10 erase count", n_erase, 2);

    // R4: retries within budget
    prep(1, 1); p_need[2] = 3; run(0, d, b);
    chk(pass, "R4 retry pass", pass, 1);
    chk(n_pcmd == N + 2, "R4 retry program commands", n_pcmd, N + 2);

    // R4: retries exhausted
    prep(1, 1); p_need[2] = PT + 1; run(0, d, b);
    chk(d && !pass, "R4 program fail", pass, 0);
    chk(n_pcmd == 2 + PT, "R4 attempts used", n_pcmd, 2 + PT);
    chk(n_erase == 0, "R4 no erase after program fail", n_erase, 0);
    chk(last_w == 8'h00, "R9 read mode after fail", last_w, 0);

    // R2: start while busy ignored
    prep(1, 1); run(40, d, b);
    chk(pass && n_pcmd == N, "R2 mid-run start ignored", n_pcmd, N);
    chk(bad_order == 0, "R2 no restart", bad_order, 0);

    // R11: empty window
    prep(1, 1); end_a = BASE; run(0, d, b);
    chk(d && pass, "R11 empty pass", pass, 1);
    chk(n_pcmd == 0 && n_erase == 0, "R11 no activity", n_pcmd + n_erase, 0);
    chk(last_w == 8'h00, "R11 read mode", last_w, 0);
    end_a = BASE + N;

    // R9: result held until next start
    repeat (5) @(negedge clk);
    chk(pass && !busy, "R9 pass held", pass, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule